// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a first-in first-out buffer of 64 words of 36 bits. A producer writes it on one clock and a consumer reads it on another, and the two clocks need not be related. Each side sees only the flags that belong to it. The writer gets an active-low full flag and an active-low almost-full flag. The reader gets an active-low empty flag and an active-low almost-empty flag. Every flag is computed in its own clock domain. It is computed from that domain's own pointer and from the other domain's pointer, which arrives after two flip-flop stages.

A flag that the local side's own action sets changes on the same edge as that action. A write sets full, and a read sets empty. A flag that the far side's action releases waits until two rising edges of the local clock have passed since that action. A single almost-threshold X sets both the almost-empty and the almost-full levels. X is picked from four presets while reset is held.

Top module: `afifo_dual_clock`

## Requirements
- R1: After reset both pointers are at zero and the flags read `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1. The output register `rd_data` reads zero.
- R2: Words come out in the order they were written. An accepted read loads the oldest word into `rd_data` on that read-clock edge.
- R3: After a write into an empty FIFO, `empty_n` stays LOW after the first rising read-clock edge. It goes HIGH on the second edge, so the earliest read is on the third edge. A read that takes the last word drives `empty_n` LOW on that same edge.
- R4: While `empty_n` is LOW a read request has no effect. `rd_data` holds its value and no word is used up.
- R5: After 64 accepted writes `full_n` is LOW. A write request while `full_n` is LOW is dropped, and the dropped word never reaches the output.
- R6: After a read frees a location in a full FIFO, `full_n` stays LOW after the first rising write-clock edge and goes HIGH on the second.
- R7: `aempty_n` is LOW when X or fewer words are held and HIGH when X+1 or more are held. It reaches HIGH on the second rising read-clock edge after the write that makes the count X+1.
- R8: `afull_n` is LOW when 64−X or more words are held and HIGH when 63−X or fewer are held. A write that raises the count updates it on the same edge. A read that lowers the count reaches it after two write-clock edges.
- R9: `thr_sel` is sampled while the resets are LOW and picks X. The code 0 gives 16, 1 gives 12, 2 gives 8 and 3 gives 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | LOW when no location is free |
| afull_n | output | 1 | LOW when 64−X or more words are held |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered output word |
| empty_n | output | 1 | LOW when no word is readable |
| aempty_n | output | 1 | LOW when X or fewer words are held |
| thr_sel | input | 2 | Threshold preset code, sampled during reset |

## Verification
The hardest states to reach are the flag releases caused by the far side, and above all the one edge where a flag must still read LOW. To make that edge observable, the stimulus runs both clocks at 125 MHz with a fixed 3 ns phase offset. Each cross-domain event then lands at a known distance before the next opposing edge. The bench samples the flag 1 ns after the first and after the second of those edges. The full-side release can only be reached once the buffer is completely full, so that scenario first writes 64 words and then tries a write that must be dropped. Only after that does it read a single word.

// File: rtl/afifo_pkg.sv
// Package afifo_pkg
// Shared types and helpers for the dual-clock FIFO: the threshold preset
// code, its decoded offset, and Gray-code conversion on a fixed maximum
// width. Callers zero-extend narrower pointers before conversion.
package afifo_pkg;

    localparam int unsigned MAX_W = 16;

    typedef enum logic [1:0] {
        THR_16 = 2'd0,
        THR_12 = 2'd1,
        THR_8  = 2'd2,
        THR_4  = 2'd3
    } thr_sel_e;

    // Decode the preset code into the almost-threshold word count.
    function automatic logic [7:0] thr_offset(input thr_sel_e s);
        case (s)
            THR_16:  return 8'd16;
            THR_12:  return 8'd12;
            THR_8:   return 8'd8;
            default: return 8'd4;
        endcase
    endfunction

    // Binary to reflected Gray code.
    function automatic logic [MAX_W-1:0] bin2gray(input logic [MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [MAX_W-1:0] gray2bin(input logic [MAX_W-1:0] g);
        logic [MAX_W-1:0] b;
        b[MAX_W-1] = g[MAX_W-1];
        for (int i = MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
// Module afifo_sync
// Two-stage flip-flop synchronizer for a Gray-coded pointer entering a
// new clock domain. Assumes at most one bit of the input changes between
// destination edges, so any captured value is a valid pointer.
module afifo_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the foreign pointer through two destination-clock flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/afifo_wr_ctrl.sv
// Module afifo_wr_ctrl
// Write-domain control: holds the write pointer, publishes it in Gray
// code, and derives full and almost-full from the local pointer and the
// synchronized read pointer. Assumes the read pointer input has already
// passed through two flops in this clock domain.
module afifo_wr_ctrl #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned PTR_W = 7,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        thr_sel,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  rd_gray_sync,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PTR_W-1:0]  wr_gray,
    output logic              wr_accept,
    output logic              full_n,
    output logic              afull_n
);

    localparam int unsigned MW = afifo_pkg::MAX_W;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] wgray_q;
    logic [PTR_W-1:0] x_q;
    logic [PTR_W-1:0] rptr_bin;
    logic [PTR_W-1:0] level;
    logic [PTR_W-1:0] wptr_next;

    // Latch the almost-threshold while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= PTR_W'(afifo_pkg::thr_offset(afifo_pkg::thr_sel_e'(thr_sel)));
        end
    end

    // Fill level as seen from the write domain.
    always_comb begin
        rptr_bin  = PTR_W'(afifo_pkg::gray2bin(MW'(rd_gray_sync)));
        level     = wptr_q - rptr_bin;
        full_n    = (level != DEPTH_P);
        afull_n   = (level < (DEPTH_P - x_q));
        wr_accept = wr_en & full_n;
        wptr_next = wptr_q + PTR_W'(wr_accept);
    end

    // Advance the binary pointer and its registered Gray copy together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            wgray_q <= '0;
        end else begin
            wptr_q  <= wptr_next;
            wgray_q <= PTR_W'(afifo_pkg::bin2gray(MW'(wptr_next)));
        end
    end

    assign wr_addr = wptr_q[ADDR_W-1:0];
    assign wr_gray = wgray_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_P);                                            // R5
    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full_n) |=> (wptr_q == $past(wptr_q)));            // R5
    AST_WR_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(wgray_q ^ $past(wgray_q)) <= 1));        // R6
    AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !afull_n);                                        // R8

endmodule

// File: rtl/afifo_rd_ctrl.sv
// Module afifo_rd_ctrl
// Read-domain control: holds the read pointer, publishes it in Gray code,
// and derives empty and almost-empty from the local pointer and the
// synchronized write pointer. Assumes the write pointer input has already
// passed through two flops in this clock domain.
module afifo_rd_ctrl #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned PTR_W = 7,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        thr_sel,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  wr_gray_sync,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  rd_gray,
    output logic              rd_accept,
    output logic              empty_n,
    output logic              aempty_n
);

    localparam int unsigned MW = afifo_pkg::MAX_W;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    logic [PTR_W-1:0] rptr_q;
    logic [PTR_W-1:0] rgray_q;
    logic [PTR_W-1:0] x_q;
    logic [PTR_W-1:0] wptr_bin;
    logic [PTR_W-1:0] level;
    logic [PTR_W-1:0] rptr_next;

    // Latch the almost-threshold while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= PTR_W'(afifo_pkg::thr_offset(afifo_pkg::thr_sel_e'(thr_sel)));
        end
    end

    // Fill level as seen from the read domain.
    always_comb begin
        wptr_bin  = PTR_W'(afifo_pkg::gray2bin(MW'(wr_gray_sync)));
        level     = wptr_bin - rptr_q;
        empty_n   = (level != '0);
        aempty_n  = (level > x_q);
        rd_accept = rd_en & empty_n;
        rptr_next = rptr_q + PTR_W'(rd_accept);
    end

    // Advance the binary pointer and its registered Gray copy together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            rgray_q <= '0;
        end else begin
            rptr_q  <= rptr_next;
            rgray_q <= PTR_W'(afifo_pkg::bin2gray(MW'(rptr_next)));
        end
    end

    assign rd_addr = rptr_q[ADDR_W-1:0];
    assign rd_gray = rgray_q;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_P);                                            // R4
    AST_EMPTY_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty_n) |=> (rptr_q == $past(rptr_q)));           // R4
    AST_RD_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(rgray_q ^ $past(rgray_q)) <= 1));        // R3
    AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);                                      // R7

endmodule

// File: rtl/afifo_dual_clock.sv
// Module afifo_dual_clock
// Top of the dual-clock FIFO: a register array written on the write
// clock and read into an output register on the read clock. The two
// pointer control blocks exchange Gray pointers through two-flop
// synchronizers. Assumes both resets are held together for several
// cycles of each clock, with thr_sel stable throughout.
module afifo_dual_clock #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 36
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n,
    input  logic [1:0]        thr_sel
);

    localparam int unsigned ADDR_W = $clog2(DEPTH);
    localparam int unsigned PTR_W  = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_data_q;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  rd_gray;
    logic [PTR_W-1:0]  wr_gray_in_rd;
    logic [PTR_W-1:0]  rd_gray_in_wr;
    logic              wr_accept;
    logic              rd_accept;

    afifo_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) i_wr_ctrl (
        .clk          (wr_clk),
        .rst_n        (wr_rst_n),
        .thr_sel      (thr_sel),
        .wr_en        (wr_en),
        .rd_gray_sync (rd_gray_in_wr),
        .wr_addr      (wr_addr),
        .wr_gray      (wr_gray),
        .wr_accept    (wr_accept),
        .full_n       (full_n),
        .afull_n      (afull_n)
    );

    afifo_rd_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) i_rd_ctrl (
        .clk          (rd_clk),
        .rst_n        (rd_rst_n),
        .thr_sel      (thr_sel),
        .rd_en        (rd_en),
        .wr_gray_sync (wr_gray_in_rd),
        .rd_addr      (rd_addr),
        .rd_gray      (rd_gray),
        .rd_accept    (rd_accept),
        .empty_n      (empty_n),
        .aempty_n     (aempty_n)
    );

    afifo_sync #(.W(PTR_W)) i_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_in_rd)
    );

    afifo_sync #(.W(PTR_W)) i_sync_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rd_gray),
        .q     (rd_gray_in_wr)
    );

    // Store an accepted word at the write address.
    always_ff @(posedge wr_clk) begin
        if (wr_accept) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Load the oldest word into the output register on an accepted read.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_data_q <= '0;
        end else if (rd_accept) begin
            rd_data_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_data_q;

endmodule

// File: tb/test_afifo_dual_clock.sv
module test_afifo_dual_clock;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  thr_sel = 2'd0;
    logic        full_n, afull_n, empty_n, aempty_n;
    logic [35:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [35:0] mdl[$];

    afifo_dual_clock i_afifo_dual_clock (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .full_n   (full_n),
        .afull_n  (afull_n),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .empty_n  (empty_n),
        .aempty_n (aempty_n),
        .thr_sel  (thr_sel)
    );

    // 125 MHz on both sides; read clock lags by 3 ns.
    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        thr_sel  = sel;
        wr_en    = 1'b0;
        rd_en    = 1'b0;
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        mdl.delete();
        #40;
    endtask

    task automatic push(input logic [35:0] d);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge wr_clk);
        #1 wr_en = 1'b0;
        if (mdl.size() < 64) mdl.push_back(d);
    endtask

    task automatic pop_check(input string req);
        logic [35:0] exp;
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(posedge rd_clk);
        #1 rd_en = 1'b0;
        exp = mdl.pop_front();
        check(req, rd_data, exp);
    endtask

    task automatic t_reset();
        do_reset(2'd0);
        check("R1 empty_n", 36'(empty_n), 36'd0);
        check("R1 aempty_n", 36'(aempty_n), 36'd0);
        check("R1 full_n", 36'(full_n), 36'd1);
        check("R1 afull_n", 36'(afull_n), 36'd1);
        check("R1 rd_data", rd_data, 36'd0);
    endtask

    task automatic t_empty_timing();
        push(36'h1_2345_6789);
        @(posedge rd_clk);
        #1 check("R3 empty_n after 1st edge", 36'(empty_n), 36'd0);
        @(posedge rd_clk);
        #1 check("R3 empty_n after 2nd edge", 36'(empty_n), 36'd1);
        pop_check("R2 single word");
        check("R3 empty_n after last read", 36'(empty_n), 36'd0);
    endtask

    task automatic t_empty_ignore();
        logic [35:0] held;
        held = rd_data;
        @(negedge rd_clk);
        rd_en = 1'b1;
        repeat (5) @(posedge rd_clk);
        #1 rd_en = 1'b0;
        check("R4 rd_data held", rd_data, held);
        check("R4 empty_n stays low", 36'(empty_n), 36'd0);
        push(36'hA_BCDE_F012);
        #80;
        pop_check("R4 no word consumed");
    endtask

    task automatic t_order();
        for (int i = 0; i < 5; i++) push(36'h0_5500_0000 + 36'(i));
        #80;
        for (int i = 0; i < 3; i++) pop_check("R2 order A");
        for (int i = 0; i < 3; i++) push(36'hF_00AA_0000 ^ 36'(i * 7));
        #80;
        for (int i = 0; i < 5; i++) pop_check("R2 order B");
    endtask

    task automatic t_full();
        do_reset(2'd2);   // X = 8
        for (int i = 0; i < 55; i++) push(36'h3_0000_0000 + 36'(i));
        #80;
        check("R8 afull_n at 55", 36'(afull_n), 36'd1);
        push(36'h3_0000_0037);
        check("R8 afull_n at 56 same edge", 36'(afull_n), 36'd0);
        for (int i = 56; i < 64; i++) push(36'h3_0000_0000 + 36'(i));
        check("R5 full_n at 64", 36'(full_n), 36'd0);
        push(36'hD_EADD_EADD);
        check("R5 full_n after dropped write", 36'(full_n), 36'd0);
        #80;
        pop_check("R5 first word");
        @(posedge wr_clk);
        #1 check("R6 full_n after 1st wr edge", 36'(full_n), 36'd0);
        @(posedge wr_clk);
        #1 check("R6 full_n after 2nd wr edge", 36'(full_n), 36'd1);
        push(36'h7_7777_7777);
        check("R5 full_n refilled", 36'(full_n), 36'd0);
        while (mdl.size() > 56) pop_check("R5 drain data");
        #80;
        check("R8 afull_n at 56", 36'(afull_n), 36'd0);
        pop_check("R5 drain data");
        #80;
        check("R8 afull_n at 55", 36'(afull_n), 36'd1);
        while (mdl.size() > 0) pop_check("R5 drain data");
        check("R5 empty after drain", 36'(empty_n), 36'd0);
    endtask

    task automatic t_thresholds();
        for (int s = 0; s < 4; s++) begin
            int x;
            x = 16 - 4 * s;
            do_reset(2'(s));
            for (int i = 0; i < x; i++) push(36'h9_0000_0000 + 36'(i));
            #80;
            check("R9 aempty_n at X", 36'(aempty_n), 36'd0);
            push(36'h9_FFFF_0000);
            @(posedge rd_clk);
            #1 check("R7 aempty_n after 1st edge", 36'(aempty_n), 36'd0);
            @(posedge rd_clk);
            #1 check("R9 aempty_n at X+1", 36'(aempty_n), 36'd1);
            pop_check("R2 threshold data");
            check("R7 aempty_n back to X", 36'(aempty_n), 36'd0);
        end
    endtask

    initial begin
        t_reset();
        t_empty_timing();
        t_empty_ignore();
        t_order();
        t_full();
        t_thresholds();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule